// File: doc/BRIEF.md
# USB Endpoint Status and Clear Unit

This block holds the status flags of the eight physical endpoints of a small USB device controller. A packet engine reports one event per cycle on an endpoint: an ACKed packet received (marked SETUP or not), a NAK sent, an ACK sent after an OUT, or an ACK received after an IN. The same engine loads the two-buffer fill state of an endpoint whenever it changes. It also asks the block whether a token must be answered with NAK.

Software reaches the flags through a byte-wide command port. A select/clear command names one endpoint and returns one status byte. The returned byte shows the flags as they stood before the command. The command then clears that endpoint's SETUP and overwritten flags and its interrupt-pending bit. An interrupt-pending vector collects endpoint events and drives a single interrupt line.

The command port is a two-state machine. In `ST_IDLE` a legal code takes transition `T_ACCEPT` into `ST_HOLD`. That transition captures the status byte and fires the clear. In `ST_HOLD` the byte is held until the read strobe takes transition `T_READ` back to `ST_IDLE`.

Top module: `usb_ep_status`

## Requirements
- R1: After reset all endpoint flags, buffer states and interrupt-pending bits are zero, `irq` is low and no status byte is pending.
- R2: Command code 0x40+n selects endpoint n for n in 0..7. Any other code returns no status byte and clears nothing.
- R3: An accepted command raises `stat_valid` on the next cycle. `stat_valid` and `stat_data` then hold until `stat_rd`. Commands arriving while a byte is pending are ignored.
- R4: Status byte layout: bit 2 SETUP, bit 3 overwritten, bit 4 NAK, bit 5 buffer 1 full, bit 6 buffer 2 full. Bits 7, 1 and 0 read as zero.
- R5: A received-ACK event (kind 0) sets the SETUP flag to the event's SETUP marker.
- R6: A received-ACK event marked SETUP sets the overwritten flag when either buffer of that endpoint was full before the event.
- R7: A command returns the pre-command flags. Afterwards SETUP and overwritten of that endpoint are zero, and other endpoints are untouched. Only the command clears these two flags.
- R8: A command clears the interrupt-pending bit of its endpoint.
- R9: A NAK-sent event (kind 1) sets the NAK flag only when `nak_irq_en` of that endpoint is 1. Kinds 2 (ACK sent after OUT) and 3 (ACK received after IN) clear the NAK flag. A command does not clear it.
- R10: Kinds 0, 2 and 3 always set the endpoint's pending bit. Kind 1 sets it only when NAK interrupts are enabled for that endpoint. `irq` is high exactly when any pending bit is set.
- R11: `tok_nak` is high for an OUT token when both buffers of the endpoint are full. It is high for an IN token when both buffers are empty. It is low when `tok_valid` is low.
- R12: When an event and a command hit the same endpoint in one cycle, the event's settings survive the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event strobe |
| ev_ep | input | 3 | Event endpoint |
| ev_kind | input | 2 | 0 rx ACK, 1 NAK sent, 2 ACK after OUT, 3 ACK after IN |
| ev_setup | input | 1 | Received packet was SETUP |
| buf_upd | input | 1 | Buffer fill update strobe |
| buf_ep | input | 3 | Buffer update endpoint |
| buf_full | input | 2 | New full bits, bit 0 buffer 1, bit 1 buffer 2 |
| nak_irq_en | input | 8 | Per-endpoint NAK interrupt enable |
| tok_valid | input | 1 | Token query strobe |
| tok_ep | input | 3 | Token endpoint |
| tok_is_in | input | 1 | 1 for IN token, 0 for OUT |
| tok_nak | output | 1 | Token must be answered with NAK |
| cmd_wr | input | 1 | Command write strobe |
| cmd_code | input | 8 | Command code |
| stat_rd | input | 1 | Status byte read strobe |
| stat_valid | output | 1 | Status byte pending |
| stat_data | output | 8 | Status byte |
| irq_pend | output | 8 | Interrupt-pending vector |
| irq | output | 1 | Any pending bit set |

## Verification
The bench builds the block with its default eight endpoints and command base 0x40. This keeps the full space small enough to sweep. It covers every endpoint, all four buffer states, every event kind, both SETUP markers and both NAK-enable values, and reads back each endpoint's byte after each combination. The small code space also allows legal codes to be checked against codes just below and above the range. The same-cycle event/clear collision and commands issued while a byte is pending are driven directly.

// File: rtl/usb_eps_pkg.sv
package usb_eps_pkg;

    typedef enum logic [1:0] {
        EV_RX_ACK   = 2'd0,
        EV_NAK_SENT = 2'd1,
        EV_ACK_OUT  = 2'd2,
        EV_ACK_IN   = 2'd3
    } ev_kind_t;

    typedef struct packed {
        logic b2;
        logic b1;
        logic nak;
        logic po;
        logic stp;
    } ep_flags_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } cmd_state_t;

    function automatic logic [7:0] pack_status(ep_flags_t f);
        return {1'b0, f.b2, f.b1, f.nak, f.po, f.stp, 2'b00};
    endfunction

endpackage

// File: rtl/ep_flag_cell.sv
module ep_flag_cell
    import usb_eps_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ev_hit,
    input  ev_kind_t  ev_kind,
    input  logic      ev_setup,
    input  logic      nak_en,
    input  logic      buf_hit,
    input  logic [1:0] buf_full,
    input  logic      clr_hit,
    output ep_flags_t flags,
    output logic      pend
);

    ep_flags_t f_q;
    logic      pend_q;
    logic      rx_ev, nak_ev, ack_ev, pend_set;

    always_comb begin
        rx_ev    = ev_hit && (ev_kind == EV_RX_ACK);
        nak_ev   = ev_hit && (ev_kind == EV_NAK_SENT) && nak_en;
        ack_ev   = ev_hit && ((ev_kind == EV_ACK_OUT) || (ev_kind == EV_ACK_IN));
        pend_set = ev_hit && ((ev_kind != EV_NAK_SENT) || nak_en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q    <= '0;
            pend_q <= 1'b0;
        end else begin
            if (buf_hit) begin
                f_q.b1 <= buf_full[0];
                f_q.b2 <= buf_full[1];
            end
            if (rx_ev)
                f_q.stp <= ev_setup;
            else if (clr_hit)
                f_q.stp <= 1'b0;
            if (rx_ev && ev_setup && (f_q.b1 || f_q.b2))
                f_q.po <= 1'b1;
            else if (clr_hit)
                f_q.po <= 1'b0;
            if (nak_ev)
                f_q.nak <= 1'b1;
            else if (ack_ev)
                f_q.nak <= 1'b0;
            pend_q <= pend_set || (pend_q && !clr_hit);
        end
    end

    assign flags = f_q;
    assign pend  = pend_q;

    a_r5_setup_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_hit && ev_kind == EV_RX_ACK) |=> (flags.stp == $past(ev_setup)));

    a_r9_nak_on_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_hit && ev_kind == EV_NAK_SENT && nak_en) |=> flags.nak);

endmodule

// File: rtl/ep_cmd_fsm.sv
module ep_cmd_fsm
    import usb_eps_pkg::*;
#(
    parameter int NUM_EP   = 8,
    parameter int CMD_BASE = 8'h40,
    localparam int EPW     = $clog2(NUM_EP)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_wr,
    input  logic [7:0]                   cmd_code,
    input  logic                         stat_rd,
    input  logic [NUM_EP-1:0][7:0]       ep_byte,
    output logic                         cmd_fire,
    output logic [EPW-1:0]               cmd_ep,
    output logic                         stat_valid,
    output logic [7:0]                   stat_data
);

    cmd_state_t state_q, state_d;
    logic [7:0] offs;
    logic       code_ok;
    logic [7:0] data_q;

    always_comb begin
        offs    = cmd_code - 8'(CMD_BASE);
        code_ok = (cmd_code >= 8'(CMD_BASE)) && (offs < 8'(NUM_EP));
        cmd_ep  = offs[EPW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        cmd_fire = 1'b0;
        unique case (state_q)
            ST_IDLE: if (cmd_wr && code_ok) begin
                cmd_fire = 1'b1;
                state_d  = ST_HOLD;
            end
            ST_HOLD: if (stat_rd) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        data_q <= '0;
        else if (cmd_fire) data_q <= ep_byte[cmd_ep];
    end

    assign stat_valid = (state_q == ST_HOLD);
    assign stat_data  = data_q;

    a_r3_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && !stat_rd) |=> (stat_valid && $stable(stat_data)));

endmodule

// File: rtl/usb_ep_status.sv
module usb_ep_status
    import usb_eps_pkg::*;
#(
    parameter int NUM_EP   = 8,
    parameter int CMD_BASE = 8'h40,
    localparam int EPW     = $clog2(NUM_EP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [EPW-1:0]    ev_ep,
    input  logic [1:0]        ev_kind,
    input  logic              ev_setup,
    input  logic              buf_upd,
    input  logic [EPW-1:0]    buf_ep,
    input  logic [1:0]        buf_full,
    input  logic [NUM_EP-1:0] nak_irq_en,
    input  logic              tok_valid,
    input  logic [EPW-1:0]    tok_ep,
    input  logic              tok_is_in,
    output logic              tok_nak,
    input  logic              cmd_wr,
    input  logic [7:0]        cmd_code,
    input  logic              stat_rd,
    output logic              stat_valid,
    output logic [7:0]        stat_data,
    output logic [NUM_EP-1:0] irq_pend,
    output logic              irq
);

    ep_flags_t                 flags [NUM_EP];
    logic [NUM_EP-1:0][7:0]    ep_byte;
    logic [NUM_EP-1:0]         pend_v;
    logic [NUM_EP-1:0]         stp_v;
    logic                      cmd_fire;
    logic [EPW-1:0]            cmd_ep;

    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
        ep_flag_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev_hit   (ev_valid && (ev_ep == EPW'(e))),
            .ev_kind  (ev_kind_t'(ev_kind)),
            .ev_setup (ev_setup),
            .nak_en   (nak_irq_en[e]),
            .buf_hit  (buf_upd && (buf_ep == EPW'(e))),
            .buf_full (buf_full),
            .clr_hit  (cmd_fire && (cmd_ep == EPW'(e))),
            .flags    (flags[e]),
            .pend     (pend_v[e])
        );
        assign ep_byte[e] = pack_status(flags[e]);
        assign stp_v[e]   = flags[e].stp;
    end

    ep_cmd_fsm #(.NUM_EP(NUM_EP), .CMD_BASE(CMD_BASE)) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr),
        .cmd_code   (cmd_code),
        .stat_rd    (stat_rd),
        .ep_byte    (ep_byte),
        .cmd_fire   (cmd_fire),
        .cmd_ep     (cmd_ep),
        .stat_valid (stat_valid),
        .stat_data  (stat_data)
    );

    always_comb begin
        tok_nak = 1'b0;
        if (tok_valid) begin
            if (tok_is_in) tok_nak = !(flags[tok_ep].b1 || flags[tok_ep].b2);
            else           tok_nak = flags[tok_ep].b1 && flags[tok_ep].b2;
        end
    end

    assign irq_pend = pend_v;
    assign irq      = |pend_v;

    a_r8_pend_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && !ev_valid) |=> !irq_pend[$past(cmd_ep)]);

    a_r7_setup_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && !ev_valid) |=> !stp_v[$past(cmd_ep)]);

endmodule

// File: tb/tb_usb_ep_status.sv
module tb_usb_ep_status;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_valid = 0, ev_setup = 0, buf_upd = 0, tok_valid = 0, tok_is_in = 0;
    logic [2:0] ev_ep = 0, buf_ep = 0, tok_ep = 0;
    logic [1:0] ev_kind = 0, buf_full = 0;
    logic [7:0] nak_irq_en = 0;
    logic       cmd_wr = 0, stat_rd = 0;
    logic [7:0] cmd_code = 0;
    logic       tok_nak, stat_valid, irq;
    logic [7:0] stat_data, irq_pend;

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    bit m_stp[8], m_po[8], m_nak[8], m_b1[8], m_b2[8], m_pend[8];

    always #2.5 clk = ~clk;

    usb_ep_status dut (.*);

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m_byte(int e);
        return {1'b0, m_b2[e], m_b1[e], m_nak[e], m_po[e], m_stp[e], 2'b00};
    endfunction

    function automatic logic [7:0] m_pvec();
        logic [7:0] v;
        for (int e = 0; e < 8; e++) v[e] = m_pend[e];
        return v;
    endfunction

    function automatic void m_clear(int e);
        m_stp[e] = 0; m_po[e] = 0; m_pend[e] = 0;
    endfunction

    function automatic void m_event(int e, int k, bit s);
        if (k == 0) begin
            if (s && (m_b1[e] || m_b2[e])) m_po[e] = 1;
            m_stp[e] = s;
        end
        if (k == 1 && nak_irq_en[e]) m_nak[e] = 1;
        if (k >= 2) m_nak[e] = 0;
        if (k != 1 || nak_irq_en[e]) m_pend[e] = 1;
    endfunction

    task automatic do_event(int e, int k, bit s);
        @(negedge clk);
        ev_valid = 1; ev_ep = 3'(e); ev_kind = 2'(k); ev_setup = s;
        @(negedge clk);
        ev_valid = 0;
        m_event(e, k, s);
    endtask

    task automatic set_buf(int e, int f);
        @(negedge clk);
        buf_upd = 1; buf_ep = 3'(e); buf_full = 2'(f);
        @(negedge clk);
        buf_upd = 0;
        m_b1[e] = f[0]; m_b2[e] = f[1];
    endtask

    task automatic read_ep(int e, string req);
        logic [7:0] exp;
        exp = m_byte(e);
        @(negedge clk);
        cmd_wr = 1; cmd_code = 8'h40 + 8'(e);
        @(negedge clk);
        cmd_wr = 0;
        check("R3 valid after cmd", stat_valid, 1);
        check(req, stat_data, exp);
        stat_rd = 1;
        @(negedge clk);
        stat_rd = 0;
        check("R3 released after read", stat_valid, 0);
        m_clear(e);
        check("R8 pending after cmd", irq_pend, m_pvec());
    endtask

    initial begin
        for (int e = 0; e < 8; e++) begin
            m_stp[e] = 0; m_po[e] = 0; m_nak[e] = 0; m_b1[e] = 0; m_b2[e] = 0; m_pend[e] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq_pend", irq_pend, 0);
        check("R1 irq", irq, 0);
        check("R1 stat_valid", stat_valid, 0);
        read_ep(5, "R1 byte");

        // R11 NAK decision sweep
        for (int e = 0; e < 8; e++)
            for (int f = 0; f < 4; f++) begin
                set_buf(e, f);
                for (int d = 0; d < 2; d++) begin
                    tok_valid = 1; tok_ep = 3'(e); tok_is_in = d[0];
                    #1;
                    check("R11 tok_nak", tok_nak, d ? (f == 0) : (f == 3));
                    tok_valid = 0;
                    #1;
                    check("R11 idle", tok_nak, 0);
                end
                set_buf(e, 0);
            end

        // R4 R5 R6 R7 R9 R10 sweep
        for (int e = 0; e < 8; e++)
            for (int f = 0; f < 4; f++) begin
                set_buf(e, f);
                for (int k = 0; k < 4; k++)
                    for (int s = 0; s < 2; s++)
                        for (int en = 0; en < 2; en++) begin
                            nak_irq_en[e] = en[0];
                            do_event(e, k, s[0]);
                            check("R10 pending vector", irq_pend, m_pvec());
                            check("R10 irq", irq, m_pvec() != 0);
                            read_ep(e, "R4 R5 R6 R9 status byte");
                            read_ep(e, "R7 byte after clear");
                        end
                set_buf(e, 0);
                nak_irq_en[e] = 0;
                do_event(e, 3, 0);
                read_ep(e, "R9 nak cleared");
            end

        // R2 illegal codes ignored
        do_event(0, 0, 1);
        foreach (bad_codes[i]) begin
            @(negedge clk);
            cmd_wr = 1; cmd_code = bad_codes[i];
            @(negedge clk);
            cmd_wr = 0;
            check("R2 no byte for illegal code", stat_valid, 0);
            check("R2 pending kept", irq_pend, m_pvec());
        end
        read_ep(0, "R2 flags kept");

        // R3 command during pending byte ignored
        do_event(1, 0, 1);
        do_event(2, 0, 1);
        @(negedge clk); cmd_wr = 1; cmd_code = 8'h41;
        @(negedge clk); cmd_code = 8'h42;
        @(negedge clk); cmd_wr = 0;
        repeat (2) @(negedge clk);
        check("R3 still pending", stat_valid, 1);
        check("R3 first byte kept", stat_data, m_byte(1));
        stat_rd = 1; @(negedge clk); stat_rd = 0;
        m_clear(1);
        check("R3 second cmd no clear", irq_pend, m_pvec());
        read_ep(2, "R3 ep2 untouched");
        read_ep(1, "R7 ep1 cleared");

        // R12 event and clear collide
        do_event(3, 0, 1);
        begin
            logic [7:0] exp;
            exp = m_byte(3);
            @(negedge clk);
            cmd_wr = 1; cmd_code = 8'h43;
            ev_valid = 1; ev_ep = 3; ev_kind = 0; ev_setup = 1;
            @(negedge clk);
            cmd_wr = 0; ev_valid = 0;
            check("R12 returned byte", stat_data, exp);
            stat_rd = 1; @(negedge clk); stat_rd = 0;
            m_clear(3); m_event(3, 0, 1);
            check("R12 pending survives", irq_pend, m_pvec());
            read_ep(3, "R12 setup survives");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    logic [7:0] bad_codes [5] = '{8'h00, 8'h3F, 8'h48, 8'hC0, 8'hFF};

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule